// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps in-flight instructions in program order between issue and architectural update, so execution units may finish in any order while the register file and memory only ever see updates in the original sequence. At issue it hands out the index of a free slot, which becomes the tag that execution units attach to their results. Results come back on a shared broadcast bus, are parked in the tagged slot, and leave the buffer only from the oldest slot, and only once that slot has its result.

Retirement depends on the kind of instruction: a register-writing operation drives a register-file write, a store drives a memory store request using its recorded address and the parked data, and a correctly predicted branch simply frees its slot. When the oldest slot holds a branch whose prediction proved wrong, every slot is discarded, the register status table is wiped, and a one-cycle redirect carries the correct successor address back to fetch. A status table tells issue logic which slot will produce each architectural register, and a lookup port lets issue pick up results that are complete but not yet retired.

Top module: `spec_rob`

## Requirements
- R1: After reset the buffer is empty: `iss_ready` is 1, `iss_tag` is 0, `rf_we`, `st_req` and `redirect_valid` are 0, and every register reads not busy.
- R2: An issue is accepted only while fewer than DEPTH slots are in use; with DEPTH slots in use `iss_ready` is 0 and an `iss_valid` pulse changes neither `iss_tag` nor the register status table.
- R3: An accepted issue takes the slot shown on `iss_tag` in that cycle; successive accepted issues receive successive tags modulo DEPTH.
- R4: A result broadcast for tag T stores the value and marks T complete; from the next cycle the lookup port reports ready 1 and that value for T, while a slot with no result reports ready 0.
- R5: Only the oldest slot retires, and only once it is complete; younger slots that complete first wait, and retirement order equals issue order.
- R6: Kind encoding on `iss_kind` is 0 register operation, 1 store, 2 branch. Retiring a register operation raises `rf_we` with `rf_waddr` equal to the low bits of its destination and its value on `rf_wdata`; retiring a store raises `st_req` with its destination on `st_addr` and its value on `st_data`; retiring a correctly predicted branch produces no write, no store and no redirect. At most one of these actions occurs per cycle.
- R7: Issuing a register operation marks its destination busy with the new tag; retirement clears the busy bit only if the recorded tag is the retiring slot, so a younger writer of the same register keeps it busy with its own tag.
- R8: When the oldest slot is a complete branch flagged mispredicted (its result carried `res_mispred` 1 and the correct target as value), `redirect_valid` is 1 for exactly one cycle with `redirect_pc` equal to that value, nothing is written, and in the next cycle the buffer is empty with `iss_tag` 0, all registers not busy and no lookup reporting ready; younger slots never retire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_kind | input | 2 | Instruction kind: 0 register op, 1 store, 2 branch |
| iss_dest | input | ADDR_W | Register number (low bits) or store address |
| iss_ready | output | 1 | A free slot exists |
| iss_tag | output | TAG_W | Slot that an issue in this cycle receives |
| res_valid | input | 1 | Result broadcast valid |
| res_tag | input | TAG_W | Slot the result belongs to |
| res_value | input | DATA_W | Result value, store data or branch target |
| res_mispred | input | 1 | Branch result: prediction was wrong |
| lk_tag | input | TAG_W | Slot to look up |
| lk_ready | output | 1 | Looked-up slot has its result |
| lk_value | output | DATA_W | Looked-up slot value |
| rs_reg | input | REG_W | Register to query in the status table |
| rs_busy | output | 1 | Queried register has a pending producer |
| rs_tag | output | TAG_W | Slot of the pending producer |
| rf_we | output | 1 | Register-file write at retirement |
| rf_waddr | output | REG_W | Register written |
| rf_wdata | output | DATA_W | Value written |
| st_req | output | 1 | Store request at retirement |
| st_addr | output | ADDR_W | Store address |
| st_data | output | DATA_W | Store data |
| redirect_valid | output | 1 | Mispredicted branch flush and fetch restart |
| redirect_pc | output | DATA_W | Correct successor address |

## Verification
The bench completes results in reverse issue order, so a design that retired whatever finished first would emit writes out of sequence. Two writers of one register are issued and the older one retired alone; a design that cleared the busy bit unconditionally would leave the younger producer invisible to issue. The buffer is filled to DEPTH and an extra issue is offered, which a design with an off-by-one full test would swallow and later retire as a phantom write. A mispredicted branch is placed ahead of an already completed younger instruction, so a flush that leaked, lingered or left stale ready bits shows up as an unexpected write, a repeated redirect or a wrong lookup.

// File: rtl/rob_pkg.sv
package rob_pkg;
    typedef enum logic [1:0] {
        KIND_REG    = 2'd0,
        KIND_STORE  = 2'd1,
        KIND_BRANCH = 2'd2
    } kind_e;
endpackage

// File: rtl/rob_ctrl.sv
// Head/tail pointers and occupancy for the circular slot queue.
module rob_ctrl #(
    parameter  int DEPTH = 8,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic             commit,
    input  logic             flush,
    output logic [TAG_W-1:0] head,
    output logic [TAG_W-1:0] tail,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [TAG_W-1:0] head;
        logic [TAG_W-1:0] tail;
        logic [CNT_W-1:0] count;
    } ctrl_t;

    ctrl_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d = '0;
        end else begin
            if (alloc)  s_d.tail = s_q.tail + 1'b1;
            if (commit) s_d.head = s_q.head + 1'b1;
            s_d.count = s_q.count + CNT_W'(alloc) - CNT_W'(commit);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head  = s_q.head;
    assign tail  = s_q.tail;
    assign count = s_q.count;
endmodule

// File: rtl/rob_entries.sv
// Slot storage: kind, destination, value, completion and mispredict flags.
module rob_entries
    import rob_pkg::*;
#(
    parameter  int DEPTH  = 8,
    parameter  int DATA_W = 32,
    parameter  int ADDR_W = 32,
    localparam int TAG_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  kind_e             alloc_kind,
    input  logic [ADDR_W-1:0] alloc_dest,
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [DATA_W-1:0] res_value,
    input  logic              res_mis,
    input  logic              commit,
    input  logic              flush,
    input  logic [TAG_W-1:0]  head_tag,
    output kind_e             head_kind,
    output logic [ADDR_W-1:0] head_dest,
    output logic [DATA_W-1:0] head_value,
    output logic              head_ready,
    output logic              head_mis,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_ready,
    output logic [DATA_W-1:0] lk_value
);
    typedef struct packed {
        logic [DEPTH-1:0]             rdy;
        logic [DEPTH-1:0]             mis;
        logic [DEPTH-1:0][1:0]        kind;
        logic [DEPTH-1:0][ADDR_W-1:0] dest;
        logic [DEPTH-1:0][DATA_W-1:0] val;
    } slots_t;

    slots_t e_d, e_q;

    always_comb begin
        e_d = e_q;
        if (commit) e_d.rdy[head_tag] = 1'b0;
        if (alloc) begin
            e_d.rdy[alloc_tag]  = 1'b0;
            e_d.mis[alloc_tag]  = 1'b0;
            e_d.kind[alloc_tag] = alloc_kind;
            e_d.dest[alloc_tag] = alloc_dest;
        end
        if (res_valid) begin
            e_d.val[res_tag] = res_value;
            e_d.rdy[res_tag] = 1'b1;
            e_d.mis[res_tag] = res_mis;
        end
        if (flush) e_d.rdy = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign head_kind  = kind_e'(e_q.kind[head_tag]);
    assign head_dest  = e_q.dest[head_tag];
    assign head_value = e_q.val[head_tag];
    assign head_ready = e_q.rdy[head_tag];
    assign head_mis   = e_q.mis[head_tag];
    assign lk_ready   = e_q.rdy[lk_tag];
    assign lk_value   = e_q.val[lk_tag];
endmodule

// File: rtl/rob_regstat.sv
// Per-register pending-producer table.
module rob_regstat #(
    parameter  int NREG  = 32,
    parameter  int DEPTH = 8,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int REG_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [REG_W-1:0] set_reg,
    input  logic [TAG_W-1:0] set_tag,
    input  logic             clr_en,
    input  logic [REG_W-1:0] clr_reg,
    input  logic [TAG_W-1:0] clr_tag,
    input  logic             flush,
    input  logic [REG_W-1:0] rd_reg,
    output logic             rd_busy,
    output logic [TAG_W-1:0] rd_tag
);
    typedef struct packed {
        logic [NREG-1:0]            busy;
        logic [NREG-1:0][TAG_W-1:0] tag;
    } stat_t;

    stat_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (clr_en && t_q.busy[clr_reg] && (t_q.tag[clr_reg] == clr_tag))
            t_d.busy[clr_reg] = 1'b0;
        if (set_en) begin
            t_d.busy[set_reg] = 1'b1;
            t_d.tag[set_reg]  = set_tag;
        end
        if (flush) t_d.busy = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign rd_busy = t_q.busy[rd_reg];
    assign rd_tag  = t_q.tag[rd_reg];
endmodule

// File: rtl/spec_rob.sv
module spec_rob
    import rob_pkg::*;
#(
    parameter  int DEPTH  = 8,
    parameter  int NREG   = 32,
    parameter  int DATA_W = 32,
    parameter  int ADDR_W = 32,
    localparam int TAG_W  = $clog2(DEPTH),
    localparam int REG_W  = $clog2(NREG),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [1:0]        iss_kind,
    input  logic [ADDR_W-1:0] iss_dest,
    output logic              iss_ready,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [DATA_W-1:0] res_value,
    input  logic              res_mispred,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_ready,
    output logic [DATA_W-1:0] lk_value,
    input  logic [REG_W-1:0]  rs_reg,
    output logic              rs_busy,
    output logic [TAG_W-1:0]  rs_tag,
    output logic              rf_we,
    output logic [REG_W-1:0]  rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              st_req,
    output logic [ADDR_W-1:0] st_addr,
    output logic [DATA_W-1:0] st_data,
    output logic              redirect_valid,
    output logic [DATA_W-1:0] redirect_pc
);
    logic [TAG_W-1:0]  head, tail;
    logic [CNT_W-1:0]  occ;
    logic              full, empty;
    logic              alloc, commit, flush, head_done;
    kind_e             h_kind;
    logic [ADDR_W-1:0] h_dest;
    logic [DATA_W-1:0] h_value;
    logic              h_ready, h_mis;

    assign full      = (occ == CNT_W'(DEPTH));
    assign empty     = (occ == '0);
    assign head_done = !empty && h_ready;
    assign flush     = head_done && (h_kind == KIND_BRANCH) && h_mis;
    assign commit    = head_done && !flush;
    assign alloc     = iss_valid && !full && !flush;

    rob_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .alloc(alloc), .commit(commit), .flush(flush),
        .head(head), .tail(tail), .count(occ)
    );

    rob_entries #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_slots (
        .clk(clk), .rst_n(rst_n),
        .alloc(alloc), .alloc_tag(tail), .alloc_kind(kind_e'(iss_kind)),
        .alloc_dest(iss_dest),
        .res_valid(res_valid && !flush), .res_tag(res_tag),
        .res_value(res_value), .res_mis(res_mispred),
        .commit(commit), .flush(flush), .head_tag(head),
        .head_kind(h_kind), .head_dest(h_dest), .head_value(h_value),
        .head_ready(h_ready), .head_mis(h_mis),
        .lk_tag(lk_tag), .lk_ready(lk_ready), .lk_value(lk_value)
    );

    rob_regstat #(.NREG(NREG), .DEPTH(DEPTH)) u_stat (
        .clk(clk), .rst_n(rst_n),
        .set_en(alloc && (kind_e'(iss_kind) == KIND_REG)),
        .set_reg(iss_dest[REG_W-1:0]), .set_tag(tail),
        .clr_en(commit && (h_kind == KIND_REG)),
        .clr_reg(h_dest[REG_W-1:0]), .clr_tag(head),
        .flush(flush),
        .rd_reg(rs_reg), .rd_busy(rs_busy), .rd_tag(rs_tag)
    );

    assign iss_ready      = !full;
    assign iss_tag        = tail;
    assign rf_we          = commit && (h_kind == KIND_REG);
    assign rf_waddr       = h_dest[REG_W-1:0];
    assign rf_wdata       = h_value;
    assign st_req         = commit && (h_kind == KIND_STORE);
    assign st_addr        = h_dest;
    assign st_data        = h_value;
    assign redirect_valid = flush;
    assign redirect_pc    = h_value;
endmodule

// File: rtl/spec_rob_chk.sv
module spec_rob_chk #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 3,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iss_valid,
    input logic             iss_ready,
    input logic [TAG_W-1:0] iss_tag,
    input logic             rf_we,
    input logic             st_req,
    input logic             redirect_valid,
    input logic [CNT_W-1:0] occ
);
    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rf_we, st_req, redirect_valid})); // R6

    AST_REDIRECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !redirect_valid); // R8

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> (occ == '0) && iss_ready && (iss_tag == '0)); // R8

    AST_FULL_HOLDS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready && !redirect_valid) |=> (iss_tag == $past(iss_tag))); // R2

    AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready && !redirect_valid) |=> (iss_tag == TAG_W'($past(iss_tag) + 1'b1))); // R3

    AST_COMMIT_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we || st_req) |-> (occ != '0)); // R5
endmodule

bind spec_rob spec_rob_chk #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_tag(iss_tag), .rf_we(rf_we), .st_req(st_req),
    .redirect_valid(redirect_valid), .occ(occ)
);

// File: tb/spec_rob_tb.sv
module spec_rob_tb;
    localparam int DEPTH = 8;
    localparam int TAG_W = 3;
    localparam int REG_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              iss_valid = 1'b0;
    logic [1:0]        iss_kind = '0;
    logic [31:0]       iss_dest = '0;
    logic              iss_ready;
    logic [TAG_W-1:0]  iss_tag;
    logic              res_valid = 1'b0;
    logic [TAG_W-1:0]  res_tag = '0;
    logic [31:0]       res_value = '0;
    logic              res_mispred = 1'b0;
    logic [TAG_W-1:0]  lk_tag = '0;
    logic              lk_ready;
    logic [31:0]       lk_value;
    logic [REG_W-1:0]  rs_reg = '0;
    logic              rs_busy;
    logic [TAG_W-1:0]  rs_tag;
    logic              rf_we;
    logic [REG_W-1:0]  rf_waddr;
    logic [31:0]       rf_wdata;
    logic              st_req;
    logic [31:0]       st_addr;
    logic [31:0]       st_data;
    logic              redirect_valid;
    logic [31:0]       redirect_pc;

    spec_rob u_dut (.*);

    typedef struct { int kind; logic [31:0] dest; logic [31:0] val; } exp_t;
    exp_t exp_q[$];
    logic [31:0] tv [DEPTH];
    logic        tm [DEPTH];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_issue(input int k, input logic [31:0] d, input logic [31:0] v,
                            input bit mis, output logic [TAG_W-1:0] t);
        exp_t e;
        @(posedge clk); #1;
        chk(iss_ready, "R2 issue slot free", {31'd0, iss_ready}, 32'd1);
        iss_valid = 1'b1; iss_kind = 2'(k); iss_dest = d;
        t = iss_tag;
        tv[t] = v; tm[t] = mis;
        if (!(k == 2 && !mis)) begin
            e.kind = k; e.dest = d; e.val = v;
            exp_q.push_back(e);
        end
        @(posedge clk); #1;
        iss_valid = 1'b0;
    endtask

    task automatic do_result(input logic [TAG_W-1:0] t);
        @(posedge clk); #1;
        res_valid = 1'b1; res_tag = t; res_value = tv[t]; res_mispred = tm[t];
        @(posedge clk); #1;
        res_valid = 1'b0; res_mispred = 1'b0;
    endtask

    // Monitor: pops the expected retirement stream (R5, R6, R8)
    always @(negedge clk) begin
        if (rst_n && !done && (rf_we || st_req || redirect_valid)) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected retirement", {29'd0, rf_we, st_req, redirect_valid}, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (rf_we) begin
                    chk(e.kind == 0, "R5 order kind", 32'd0, e.kind);
                    chk(rf_waddr == e.dest[REG_W-1:0], "R6 rf_waddr", {27'd0, rf_waddr}, e.dest);
                    chk(rf_wdata == e.val, "R6 rf_wdata", rf_wdata, e.val);
                end else if (st_req) begin
                    chk(e.kind == 1, "R5 order kind", 32'd1, e.kind);
                    chk(st_addr == e.dest, "R6 st_addr", st_addr, e.dest);
                    chk(st_data == e.val, "R6 st_data", st_data, e.val);
                end else begin
                    chk(e.kind == 2, "R8 redirect kind", 32'd2, e.kind);
                    chk(redirect_pc == e.val, "R8 redirect_pc", redirect_pc, e.val);
                    exp_q.delete();
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [TAG_W-1:0] ta, tb_, tc, tx, tbr, ty, tq;
        logic [TAG_W-1:0] tf [DEPTH];
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        settle(1);
        // R1 reset state
        rs_reg = 5'd5;
        settle(1);
        chk(iss_ready, "R1 iss_ready", {31'd0, iss_ready}, 32'd1);
        chk(iss_tag == 0, "R1 iss_tag", {29'd0, iss_tag}, 32'd0);
        chk(!rf_we && !st_req && !redirect_valid, "R1 idle outputs",
            {29'd0, rf_we, st_req, redirect_valid}, 32'd0);
        chk(!rs_busy, "R1 rs_busy", {31'd0, rs_busy}, 32'd0);

        // R7 two writers of one register, R4 lookup, R5 ordering
        do_issue(0, 32'd5, 32'h11, 1'b0, ta);
        settle(1);
        chk(rs_busy && rs_tag == ta, "R7 first writer", {28'd0, rs_busy, rs_tag}, {28'd0, 1'b1, ta});
        do_issue(0, 32'd5, 32'h22, 1'b0, tb_);
        chk(tb_ == TAG_W'(ta + 1), "R3 sequential tag", {29'd0, tb_}, {29'd0, TAG_W'(ta + 1)});
        settle(1);
        chk(rs_busy && rs_tag == tb_, "R7 younger writer", {28'd0, rs_busy, rs_tag}, {28'd0, 1'b1, tb_});
        do_issue(1, 32'h100, 32'hAA, 1'b0, tc);
        do_result(tc);
        lk_tag = tc;
        settle(1);
        chk(lk_ready && lk_value == 32'hAA, "R4 lookup completed", lk_value, 32'hAA);
        chk(!rf_we && !st_req, "R5 head not ready blocks", {30'd0, rf_we, st_req}, 32'd0);
        lk_tag = ta;
        settle(1);
        chk(!lk_ready, "R4 lookup pending", {31'd0, lk_ready}, 32'd0);
        do_result(ta);
        settle(3);
        chk(rs_busy && rs_tag == tb_, "R7 older commit keeps younger", {28'd0, rs_busy, rs_tag}, {28'd0, 1'b1, tb_});
        do_result(tb_);
        settle(4);
        chk(!rs_busy, "R7 cleared at own commit", {31'd0, rs_busy}, 32'd0);

        // R2 fill to DEPTH, extra issue ignored; reverse completion
        for (int i = 0; i < DEPTH; i++) do_issue(0, 32'(10 + i), 32'(32'h100 + i), 1'b0, tf[i]);
        settle(1);
        chk(!iss_ready, "R2 full", {31'd0, iss_ready}, 32'd0);
        tq = iss_tag;
        @(posedge clk); #1;
        iss_valid = 1'b1; iss_kind = 2'd0; iss_dest = 32'd3;
        @(posedge clk); #1;
        iss_valid = 1'b0;
        rs_reg = 5'd3;
        settle(1);
        chk(iss_tag == tq, "R2 ignored issue tag", {29'd0, iss_tag}, {29'd0, tq});
        chk(!rs_busy, "R2 ignored issue status", {31'd0, rs_busy}, 32'd0);
        for (int i = DEPTH - 1; i >= 0; i--) do_result(tf[i]);
        settle(DEPTH + 2);
        chk(iss_ready, "R2 drained", {31'd0, iss_ready}, 32'd1);

        // R8 mispredicted branch with a completed younger entry
        do_issue(0, 32'd7, 32'h77, 1'b0, tx);
        do_issue(2, 32'd0, 32'h400, 1'b1, tbr);
        do_issue(0, 32'd9, 32'h99, 1'b0, ty);
        do_result(ty);
        do_result(tx);
        do_result(tbr);
        rs_reg = 5'd9; lk_tag = ty;
        settle(3);
        chk(iss_tag == 0 && iss_ready, "R8 emptied", {29'd0, iss_tag}, 32'd0);
        chk(!rs_busy, "R8 status wiped", {31'd0, rs_busy}, 32'd0);
        chk(!lk_ready, "R8 lookup wiped", {31'd0, lk_ready}, 32'd0);
        chk(exp_q.size() == 0, "R8 redirect seen", exp_q.size(), 32'd0);

        // R6 correctly predicted branch frees its slot silently
        do_issue(2, 32'd0, 32'h500, 1'b0, tbr);
        do_issue(0, 32'd4, 32'h44, 1'b0, tx);
        do_result(tx);
        settle(2);
        chk(!rf_we, "R5 waits behind branch", {31'd0, rf_we}, 32'd0);
        do_result(tbr);
        settle(4);
        chk(iss_tag == 2 && iss_ready, "R3 tag after branch", {29'd0, iss_tag}, 32'd2);
        chk(exp_q.size() == 0, "R5 all retired", exp_q.size(), 32'd0);
        finish_run();
    end
endmodule